// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block decides which pending exception a small processor core takes next, and it steps through handler entry, chaining from one handler to the next, and return. Three fixed system exceptions (a reset request, a non-maskable request and a hard-fault request) rank above a parameterized set of level-sensitive interrupt lines. Each line has its own enable bit and its own priority register. A control field sets how many of the implemented priority bits are compared. The unused low-order bits are ignored, so lines that differ only in those bits compete as equals.

On entry the block asks for a stack save and a vector fetch in the same cycle. The handler starts once both acknowledges have arrived. A strictly higher priority request pre-empts a running handler, up to a parameterized nesting depth. When a handler ends and another pending exception outranks the level being returned to, the block requests only the next vector: it skips both the restore and the re-save. Otherwise it requests a stack restore, and handler mode ends only when the last restore is acknowledged. A fetched vector whose mode bit (bit 0) is clear raises a one-cycle invalid-state fault when its handler starts.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, handler_mode, stk_save_req, stk_pop_req, vec_req and inv_state_fault are 0, exc_num is 0, and every line priority register holds 0.
- R2: The fixed exceptions outrank every interrupt line. Among themselves the order is reset request, then non-maskable request, then hard-fault request.
- R3: Among interrupt lines, a lower masked priority value wins. Equal masked values go to the lower line index.
- R4: A line whose enable bit is 0 never wins, whatever the level of its request.
- R5: prio_bits = k (0..PRIO_W) keeps the k most significant priority bits for comparison and treats the rest as 0. Values above PRIO_W act as PRIO_W.
- R6: Entry raises stk_save_req and vec_req in the same cycle. Each is held until its own acknowledge. The handler starts in the cycle after the later of the two acknowledges.
- R7: A pending exception pre-empts a running handler only when its rank is strictly higher than the handler's. Equal rank does not pre-empt.
- R8: At hdl_exit, if the best pending exception strictly outranks the level being returned to (the pre-empted handler, or the thread), the block raises only vec_req for it. It raises neither stk_pop_req nor stk_save_req.
- R9: Otherwise hdl_exit raises stk_pop_req until stk_pop_ack. handler_mode stays 1 during all exception activity and drops only after the acknowledge of the restore that returns to the thread.
- R10: If vec_mode_bit is 0 when the vector acknowledge completes entry or chaining, inv_state_fault is 1 for exactly the first cycle of that handler. Otherwise it stays 0.
- R11: An exiting exception whose request is still asserted at hdl_exit competes again at once, so it can be chained back into.
- R12: exc_num encodes the active exception: 1 reset request, 2 non-maskable, 3 hard fault, 16+i interrupt line i, and 0 when no exception is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_IRQ | Level-sensitive interrupt request lines |
| irq_en | input | N_IRQ | Per-line enable |
| prio_we | input | N_IRQ | Per-line priority register write strobe |
| prio_wdata | input | PRIO_W | Priority value to write |
| prio_bits | input | $clog2(PRIO_W+1) | Number of priority bits compared |
| rst_exc_req | input | 1 | Reset exception request |
| nmi_req | input | 1 | Non-maskable request |
| hf_req | input | 1 | Hard-fault request |
| hdl_exit | input | 1 | Running handler returns |
| stk_save_req | output | 1 | State save request |
| stk_save_ack | input | 1 | State save done |
| stk_pop_req | output | 1 | State restore request |
| stk_pop_ack | input | 1 | State restore done |
| vec_req | output | 1 | Vector fetch request for exc_num |
| vec_ack | input | 1 | Vector fetch done |
| vec_mode_bit | input | 1 | Bit 0 of the fetched vector, valid with vec_ack |
| exc_num | output | $clog2(16+N_IRQ) | Active exception number |
| handler_mode | output | 1 | Handler mode flag |
| inv_state_fault | output | 1 | Invalid-state fault pulse |

## Verification
A wrong arbitration result shows on exc_num one clock after the requests are applied, when the entry request pair rises. A corrupted nesting stack or active mask stays hidden until the next hdl_exit. It then shows as a restore where a chain was due, or the reverse, or as a wrong exception number after a restore to the pre-empted handler. A lost save or fetch completion flag shows as a request held too long or dropped too early, in the cycle after the acknowledge. A misrouted mode bit shows on inv_state_fault in the first handler cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_RUN,
    ST_CHAIN,
    ST_POP
  } seq_state_e;

  // Source index space: 0 reset, 1 nmi, 2 hard fault, 3.. interrupt lines
  localparam int unsigned FIXED_SRC = 3;
  localparam int unsigned IRQ_BASE  = 16;

  function automatic int unsigned idx_to_num(input int unsigned idx);
    if (idx < FIXED_SRC) return idx + 1;
    return IRQ_BASE + idx - FIXED_SRC;
  endfunction

endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IRQ-1:0]          we,
  input  logic [PRIO_W-1:0]         wdata,
  output logic [N_IRQ*PRIO_W-1:0]   prio_flat
);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] prio_d;

    always_comb begin
      prio_d = prio_q;
      if (we[g]) prio_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q <= '0;
      else        prio_q <= prio_d;
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned USE_W  = $clog2(PRIO_W + 1),
  localparam int unsigned RANK_W = PRIO_W + 2,
  localparam int unsigned NSRC   = exc_pkg::FIXED_SRC + N_IRQ,
  localparam int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic                    rst_req,
  input  logic                    nmi_req,
  input  logic                    hf_req,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [USE_W-1:0]        prio_bits,
  input  logic [NSRC-1:0]         active,
  output logic                    win_vld,
  output logic [IDX_W-1:0]        win_idx,
  output logic [RANK_W-1:0]       win_rank
);
  import exc_pkg::*;

  logic [NSRC-1:0]   src_vld;
  logic [RANK_W-1:0] src_rank [NSRC];
  logic [PRIO_W-1:0] keep_mask;

  // keep the prio_bits most significant bits
  always_comb begin
    for (int b = 0; b < PRIO_W; b++) begin
      keep_mask[b] = (int'(prio_bits) + b) >= PRIO_W;
    end
  end

  assign src_vld[0] = rst_req & ~active[0];
  assign src_vld[1] = nmi_req & ~active[1];
  assign src_vld[2] = hf_req  & ~active[2];
  assign src_rank[0] = RANK_W'(0);
  assign src_rank[1] = RANK_W'(1);
  assign src_rank[2] = RANK_W'(2);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    logic [PRIO_W-1:0] masked;
    assign masked = prio_flat[g*PRIO_W +: PRIO_W] & keep_mask;
    assign src_vld[FIXED_SRC+g]  = irq_req[g] & irq_en[g] & ~active[FIXED_SRC+g];
    assign src_rank[FIXED_SRC+g] = RANK_W'(FIXED_SRC) + {2'b00, masked};
  end

  // strict compare in ascending index order: ties keep the lower index
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_rank = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (src_vld[i] && (!win_vld || src_rank[i] < win_rank)) begin
        win_vld  = 1'b1;
        win_idx  = IDX_W'(i);
        win_rank = src_rank[i];
      end
    end
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int unsigned NSRC   = 11,
  parameter int unsigned RANK_W = 5,
  parameter int unsigned NEST   = 4,
  localparam int unsigned IDX_W   = $clog2(NSRC),
  localparam int unsigned DEPTH_W = $clog2(NEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_vld,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [RANK_W-1:0] win_rank,
  input  logic              hdl_exit,
  input  logic              stk_save_ack,
  input  logic              stk_pop_ack,
  input  logic              vec_ack,
  input  logic              vec_mode_bit,
  output logic [NSRC-1:0]   active_eff,
  output logic              top_vld,
  output logic [IDX_W-1:0]  top_idx,
  output logic              stk_save_req,
  output logic              stk_pop_req,
  output logic              vec_req,
  output logic              handler_mode,
  output logic              inv_state_fault
);
  import exc_pkg::*;

  localparam logic [RANK_W-1:0] THREAD_RANK = '1;

  seq_state_e        state_q, state_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [IDX_W-1:0]  stk_idx_q  [NEST];
  logic [IDX_W-1:0]  stk_idx_d  [NEST];
  logic [RANK_W-1:0] stk_rank_q [NEST];
  logic [RANK_W-1:0] stk_rank_d [NEST];
  logic [NSRC-1:0]   active_q, active_d;
  logic              save_done_q, save_done_d;
  logic              vec_done_q, vec_done_d;
  logic              vbit_q, vbit_d;
  logic              fault_q, fault_d;
  logic              hmode_q, hmode_d;

  logic [RANK_W-1:0] top_rank, below_rank;
  logic              exit_now, take;
  logic              save_all, vec_all;
  logic [NSRC-1:0]   win_hot, top_hot;

  // stack top and the level beneath it
  always_comb begin
    top_idx    = '0;
    top_rank   = THREAD_RANK;
    below_rank = THREAD_RANK;
    for (int k = 0; k < NEST; k++) begin
      if (DEPTH_W'(k + 1) == depth_q) begin
        top_idx  = stk_idx_q[k];
        top_rank = stk_rank_q[k];
      end
      if (DEPTH_W'(k + 2) == depth_q) below_rank = stk_rank_q[k];
    end
  end

  assign top_vld    = depth_q != '0;
  assign exit_now   = (state_q == ST_RUN) && hdl_exit;
  assign win_hot    = NSRC'(1) << win_idx;
  assign top_hot    = NSRC'(1) << top_idx;
  assign active_eff = exit_now ? (active_q & ~top_hot) : active_q;
  assign take       = win_vld && (depth_q < DEPTH_W'(NEST)) && (win_rank < top_rank);
  assign save_all   = save_done_q | stk_save_ack;
  assign vec_all    = vec_done_q | vec_ack;

  always_comb begin
    state_d     = state_q;
    depth_d     = depth_q;
    stk_idx_d   = stk_idx_q;
    stk_rank_d  = stk_rank_q;
    active_d    = active_eff;
    save_done_d = save_done_q;
    vec_done_d  = vec_done_q;
    vbit_d      = vbit_q;
    fault_d     = 1'b0;
    hmode_d     = hmode_q;

    unique case (state_q)
      ST_IDLE, ST_RUN: begin
        if (exit_now) begin
          if (win_vld && (win_rank < below_rank)) begin
            for (int k = 0; k < NEST; k++) begin
              if (DEPTH_W'(k + 1) == depth_q) begin
                stk_idx_d[k]  = win_idx;
                stk_rank_d[k] = win_rank;
              end
            end
            active_d = active_eff | win_hot;
            state_d  = ST_CHAIN;
          end else begin
            state_d = ST_POP;
          end
        end else if (take) begin
          for (int k = 0; k < NEST; k++) begin
            if (DEPTH_W'(k) == depth_q) begin
              stk_idx_d[k]  = win_idx;
              stk_rank_d[k] = win_rank;
            end
          end
          depth_d     = depth_q + DEPTH_W'(1);
          active_d    = active_eff | win_hot;
          save_done_d = 1'b0;
          vec_done_d  = 1'b0;
          hmode_d     = 1'b1;
          state_d     = ST_ENTRY;
        end
      end
      ST_ENTRY: begin
        save_done_d = save_all;
        vec_done_d  = vec_all;
        if (vec_ack) vbit_d = vec_mode_bit;
        if (save_all && vec_all) begin
          state_d = ST_RUN;
          fault_d = vec_ack ? ~vec_mode_bit : ~vbit_q;
        end
      end
      ST_CHAIN: begin
        if (vec_ack) begin
          state_d = ST_RUN;
          fault_d = ~vec_mode_bit;
        end
      end
      ST_POP: begin
        if (stk_pop_ack) begin
          depth_d = depth_q - DEPTH_W'(1);
          if (depth_q == DEPTH_W'(1)) begin
            state_d = ST_IDLE;
            hmode_d = 1'b0;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      depth_q     <= '0;
      active_q    <= '0;
      save_done_q <= 1'b0;
      vec_done_q  <= 1'b0;
      vbit_q      <= 1'b0;
      fault_q     <= 1'b0;
      hmode_q     <= 1'b0;
      for (int k = 0; k < NEST; k++) begin
        stk_idx_q[k]  <= '0;
        stk_rank_q[k] <= '0;
      end
    end else begin
      state_q     <= state_d;
      depth_q     <= depth_d;
      active_q    <= active_d;
      save_done_q <= save_done_d;
      vec_done_q  <= vec_done_d;
      vbit_q      <= vbit_d;
      fault_q     <= fault_d;
      hmode_q     <= hmode_d;
      for (int k = 0; k < NEST; k++) begin
        stk_idx_q[k]  <= stk_idx_d[k];
        stk_rank_q[k] <= stk_rank_d[k];
      end
    end
  end

  assign stk_save_req    = (state_q == ST_ENTRY) && !save_done_q;
  assign vec_req         = ((state_q == ST_ENTRY) && !vec_done_q) || (state_q == ST_CHAIN);
  assign stk_pop_req     = state_q == ST_POP;
  assign handler_mode    = hmode_q;
  assign inv_state_fault = fault_q;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned NEST   = 4,
  localparam int unsigned USE_W  = $clog2(PRIO_W + 1),
  localparam int unsigned RANK_W = PRIO_W + 2,
  localparam int unsigned NSRC   = exc_pkg::FIXED_SRC + N_IRQ,
  localparam int unsigned IDX_W  = $clog2(NSRC),
  localparam int unsigned EXC_W  = $clog2(exc_pkg::IRQ_BASE + N_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_IRQ-1:0]  prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic [USE_W-1:0]  prio_bits,
  input  logic              rst_exc_req,
  input  logic              nmi_req,
  input  logic              hf_req,
  input  logic              hdl_exit,
  output logic              stk_save_req,
  input  logic              stk_save_ack,
  output logic              stk_pop_req,
  input  logic              stk_pop_ack,
  output logic              vec_req,
  input  logic              vec_ack,
  input  logic              vec_mode_bit,
  output logic [EXC_W-1:0]  exc_num,
  output logic              handler_mode,
  output logic              inv_state_fault
);
  import exc_pkg::*;

  logic [N_IRQ*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]         active_eff;
  logic                    win_vld;
  logic [IDX_W-1:0]        win_idx;
  logic [RANK_W-1:0]       win_rank;
  logic                    top_vld;
  logic [IDX_W-1:0]        top_idx;

  exc_prio_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (prio_we),
    .wdata     (prio_wdata),
    .prio_flat (prio_flat)
  );

  exc_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .rst_req   (rst_exc_req),
    .nmi_req   (nmi_req),
    .hf_req    (hf_req),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .prio_flat (prio_flat),
    .prio_bits (prio_bits),
    .active    (active_eff),
    .win_vld   (win_vld),
    .win_idx   (win_idx),
    .win_rank  (win_rank)
  );

  exc_seq #(.NSRC(NSRC), .RANK_W(RANK_W), .NEST(NEST)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .win_vld         (win_vld),
    .win_idx         (win_idx),
    .win_rank        (win_rank),
    .hdl_exit        (hdl_exit),
    .stk_save_ack    (stk_save_ack),
    .stk_pop_ack     (stk_pop_ack),
    .vec_ack         (vec_ack),
    .vec_mode_bit    (vec_mode_bit),
    .active_eff      (active_eff),
    .top_vld         (top_vld),
    .top_idx         (top_idx),
    .stk_save_req    (stk_save_req),
    .stk_pop_req     (stk_pop_req),
    .vec_req         (vec_req),
    .handler_mode    (handler_mode),
    .inv_state_fault (inv_state_fault)
  );

  assign exc_num = top_vld ? EXC_W'(idx_to_num(int'(top_idx))) : '0;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int unsigned EXC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stk_save_req,
  input logic             stk_save_ack,
  input logic             stk_pop_req,
  input logic             stk_pop_ack,
  input logic             vec_req,
  input logic             vec_ack,
  input logic [EXC_W-1:0] exc_num,
  input logic             handler_mode,
  input logic             inv_state_fault
);

  p_pair_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_save_req) |-> $rose(vec_req));

  p_save_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_save_req && !stk_save_ack) |=> stk_save_req);

  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_ack) |=> vec_req);

  p_no_mix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_pop_req && (stk_save_req || vec_req)));

  p_req_in_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_save_req || vec_req || stk_pop_req) |-> handler_mode);

  p_mode_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(handler_mode) |-> $past(stk_pop_ack && stk_pop_req));

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_state_fault |=> !inv_state_fault);

  p_fault_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_state_fault |-> (handler_mode && !vec_req && !stk_save_req));

  p_num_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> (exc_num != '0));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.EXC_W(EXC_W)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .stk_save_req    (stk_save_req),
  .stk_save_ack    (stk_save_ack),
  .stk_pop_req     (stk_pop_req),
  .stk_pop_ack     (stk_pop_ack),
  .vec_req         (vec_req),
  .vec_ack         (vec_ack),
  .exc_num         (exc_num),
  .handler_mode    (handler_mode),
  .inv_state_fault (inv_state_fault)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int N_IRQ  = 8;
  localparam int PRIO_W = 3;

  logic              clk;
  logic              rst_n;
  logic [N_IRQ-1:0]  irq_req, irq_en, prio_we;
  logic [PRIO_W-1:0] prio_wdata;
  logic [1:0]        prio_bits;
  logic              rst_exc_req, nmi_req, hf_req, hdl_exit;
  logic              stk_save_req, stk_save_ack, stk_pop_req, stk_pop_ack;
  logic              vec_req, vec_ack, vec_mode_bit;
  logic [4:0]        exc_num;
  logic              handler_mode, inv_state_fault;

  int checks = 0;
  int errors = 0;

  exc_entry_ctrl #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .prio_we(prio_we), .prio_wdata(prio_wdata), .prio_bits(prio_bits),
    .rst_exc_req(rst_exc_req), .nmi_req(nmi_req), .hf_req(hf_req),
    .hdl_exit(hdl_exit), .stk_save_req(stk_save_req), .stk_save_ack(stk_save_ack),
    .stk_pop_req(stk_pop_req), .stk_pop_ack(stk_pop_ack), .vec_req(vec_req),
    .vec_ack(vec_ack), .vec_mode_bit(vec_mode_bit), .exc_num(exc_num),
    .handler_mode(handler_mode), .inv_state_fault(inv_state_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    irq_req = '0; irq_en = '1; prio_we = '0; prio_wdata = '0; prio_bits = 2'd3;
    rst_exc_req = 0; nmi_req = 0; hf_req = 0; hdl_exit = 0;
    stk_save_ack = 0; stk_pop_ack = 0; vec_ack = 0; vec_mode_bit = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic wr_prio(input int line, input int val);
    prio_we = N_IRQ'(1) << line;
    prio_wdata = PRIO_W'(val);
    step();
    prio_we = '0;
  endtask

  task automatic enter_ack(input logic mb);
    stk_save_ack = 1; vec_ack = 1; vec_mode_bit = mb;
    step();
    stk_save_ack = 0; vec_ack = 0;
  endtask

  task automatic chain_ack(input logic mb);
    vec_ack = 1; vec_mode_bit = mb;
    step();
    vec_ack = 0;
  endtask

  task automatic exit_hdl();
    hdl_exit = 1;
    step();
    hdl_exit = 0;
  endtask

  task automatic pop_ack();
    stk_pop_ack = 1;
    step();
    stk_pop_ack = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 handler_mode", handler_mode, 0);
    chk("R1 save_req", stk_save_req, 0);
    chk("R1 vec_req", vec_req, 0);
    chk("R1 pop_req", stk_pop_req, 0);
    chk("R1 fault", inv_state_fault, 0);
    chk("R12 exc_num idle", exc_num, 0);
  endtask

  task automatic t_basic();
    do_reset();
    irq_req[0] = 1;
    step();
    chk("R6 save_req at entry", stk_save_req, 1);
    chk("R6 vec_req at entry", vec_req, 1);
    chk("R12 exc_num line0", exc_num, 16);
    chk("R9 mode at entry", handler_mode, 1);
    stk_save_ack = 1; step(); stk_save_ack = 0;
    chk("R6 save dropped after ack", stk_save_req, 0);
    chk("R6 vec held", vec_req, 1);
    vec_ack = 1; vec_mode_bit = 1; step(); vec_ack = 0;
    chk("R6 vec dropped, handler runs", vec_req, 0);
    chk("R10 no fault on odd vector", inv_state_fault, 0);
    irq_req[0] = 0;
    exit_hdl();
    chk("R9 restore requested", stk_pop_req, 1);
    chk("R9 mode held during restore", handler_mode, 1);
    step();
    chk("R9 restore held", stk_pop_req, 1);
    pop_ack();
    chk("R9 mode drops after restore", handler_mode, 0);
    chk("R12 exc_num back to 0", exc_num, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    irq_en[1] = 0;
    irq_req[1] = 1;
    repeat (4) step();
    chk("R4 disabled line no entry", stk_save_req, 0);
    chk("R4 disabled line mode", handler_mode, 0);
    irq_req[2] = 1;
    step();
    chk("R4 enabled higher number wins", exc_num, 18);
  endtask

  task automatic t_order();
    do_reset();
    wr_prio(2, 5);
    wr_prio(5, 2);
    irq_req[2] = 1; irq_req[5] = 1;
    step();
    chk("R3 lower value wins", exc_num, 21);
    do_reset();
    irq_req[2] = 1; irq_req[5] = 1;
    step();
    chk("R1 R3 priorities reset to 0, tie to lower line", exc_num, 18);
  endtask

  task automatic t_mask();
    do_reset();
    wr_prio(2, 5); wr_prio(5, 4);
    irq_req[2] = 1; irq_req[5] = 1;
    step();
    chk("R5 all bits compared", exc_num, 21);
    do_reset();
    wr_prio(2, 5); wr_prio(5, 4);
    prio_bits = 2'd1;
    irq_req[2] = 1; irq_req[5] = 1;
    step();
    chk("R5 one bit compared", exc_num, 18);
    do_reset();
    wr_prio(2, 6); wr_prio(5, 1);
    prio_bits = 2'd0;
    irq_req[2] = 1; irq_req[5] = 1;
    step();
    chk("R5 zero bits compared", exc_num, 18);
  endtask

  task automatic t_fixed();
    do_reset();
    rst_exc_req = 1; nmi_req = 1; hf_req = 1; irq_req[0] = 1;
    step();
    chk("R2 reset request first", exc_num, 1);
    enter_ack(1);
    rst_exc_req = 0;
    exit_hdl();
    chk("R2 nmi next", exc_num, 2);
    chk("R8 chain fetch", vec_req, 1);
    chk("R8 chain no save", stk_save_req, 0);
    chk("R8 chain no restore", stk_pop_req, 0);
    chain_ack(1);
    nmi_req = 0;
    exit_hdl();
    chk("R2 hard fault next", exc_num, 3);
    chain_ack(1);
    hf_req = 0;
    exit_hdl();
    chk("R2 line after fixed", exc_num, 16);
    chk("R8 chain into line", vec_req, 1);
    chain_ack(1);
    irq_req[0] = 0;
    exit_hdl();
    chk("R9 final restore", stk_pop_req, 1);
    pop_ack();
    chk("R9 thread after chain run", handler_mode, 0);
  endtask

  task automatic t_preempt();
    do_reset();
    wr_prio(3, 2); wr_prio(4, 2); wr_prio(6, 1);
    irq_req[3] = 1;
    step();
    enter_ack(1);
    chk("R12 line3 running", exc_num, 19);
    irq_req[4] = 1;
    repeat (3) step();
    chk("R7 equal rank no pre-empt save", stk_save_req, 0);
    chk("R7 equal rank keeps number", exc_num, 19);
    irq_req[6] = 1;
    step();
    chk("R7 higher rank pre-empts", stk_save_req, 1);
    chk("R7 pre-empting number", exc_num, 22);
    enter_ack(1);
    irq_req[6] = 0;
    exit_hdl();
    chk("R8 equal to return level restores", stk_pop_req, 1);
    chk("R8 no chain to equal rank", vec_req, 0);
    pop_ack();
    chk("R9 back in pre-empted handler", exc_num, 19);
    chk("R9 mode kept after nested restore", handler_mode, 1);
    irq_req[3] = 0;
    exit_hdl();
    chk("R8 chain over thread", vec_req, 1);
    chk("R8 chain no restore", stk_pop_req, 0);
    chk("R8 chained number", exc_num, 20);
    chain_ack(1);
    irq_req[4] = 0;
    exit_hdl();
    pop_ack();
    chk("R9 thread at end", handler_mode, 0);
  endtask

  task automatic t_hazard();
    do_reset();
    irq_req[0] = 1;
    step();
    enter_ack(1);
    exit_hdl();
    chk("R11 late clear re-enters", vec_req, 1);
    chk("R11 no restore", stk_pop_req, 0);
    chk("R11 same number", exc_num, 16);
    chain_ack(1);
    irq_req[0] = 0;
    exit_hdl();
    pop_ack();
    chk("R11 thread after clear", handler_mode, 0);
  endtask

  task automatic t_fault();
    do_reset();
    irq_req[0] = 1;
    step();
    enter_ack(0);
    chk("R10 fault on even vector", inv_state_fault, 1);
    step();
    chk("R10 fault one cycle", inv_state_fault, 0);
    exit_hdl();
    chk("R11 still pending chain", vec_req, 1);
    chain_ack(0);
    chk("R10 fault on chained even vector", inv_state_fault, 1);
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    t_reset();
    t_basic();
    t_disabled();
    t_order();
    t_mask();
    t_fixed();
    t_preempt();
    t_hazard();
    t_fault();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule